// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master

This block is a byte-wide serial peripheral master with a small register file on its host side. Software programs the clock polarity, the clock phase, the bit order, the serial clock divisor and an interrupt enable. It then writes one byte to the data register, and that write starts an exchange. During the exchange the block drives the serial clock, the outgoing data line and an active-low select, and it samples the incoming data line. When the eighth bit has been captured, the received byte can be read from the data register.

The host port is a flat register interface. It has an index, a write strobe, write data and combinational read data. Completion is recorded in a status bit that software clears by writing one to it. That bit, gated by the interrupt enable, drives the interrupt output. The system clock is taken to run at twice the base serial rate, so one serial half-period lasts 1 system clock for divisor code 0 and 2×code system clocks for any other code.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, index F0h reads 0x10, index F2h reads 0x01, index F4h reads 0x00, status bit 7 reads 0, `cs_n` is 1, `sck` is 0 and `irq` is 0.
- R2: The control register at index F0h holds interrupt enable in bit 5, master enable in bit 4, clock polarity in bit 3, clock phase in bit 2 and LSB-first in bit 0. Bits 7, 6 and 1 always read as 0.
- R3: The divisor register at index F2h holds a code in bits 2..0 that reads back as written. Each serial half-period lasts H system clocks, where H is 1 for code 0 and 2×code for any other code. An exchange keeps `cs_n` low for exactly 16×H clocks.
- R4: While no exchange is running, `sck` equals the clock polarity bit.
- R5: With clock phase 0, the first `sck` edge comes H clocks after the start, and the last edge falls on the release of `cs_n`. With clock phase 1, the first edge comes in the same cycle that `cs_n` falls, and `sck` sits at its idle level for the final half-period. In both phases there are 16 edges. Incoming data is sampled on the odd-numbered half-period boundaries, and outgoing data changes on the even-numbered ones.
- R6: With LSB-first 0, bit 7 is sent first and the first received bit lands in bit 7. With LSB-first 1, bit 0 is sent first and the first received bit lands in bit 0.
- R7: Writing index F4h while idle, with master enable set, starts an exchange in the next cycle. Such a write made during an exchange is ignored and does not change `mosi`.
- R8: With master enable at 0, writing index F4h does not start an exchange: `cs_n` stays 1.
- R9: Status at index F3h: bit 7 is set at the end of each exchange and cleared by writing 1 to it (if both happen in the same cycle, the set wins). Bit 5 mirrors `spi_en_in`. Bit 0 reads 1 during an exchange. All other bits read 0.
- R10: `irq` is 1 exactly when status bit 7 and the interrupt enable are both 1.
- R11: After an exchange, index F4h reads the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the base serial rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx` |
| spi_en_in | input | 1 | External enable level, mirrored in status |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Outgoing serial data |
| miso | input | 1 | Incoming serial data |
| cs_n | output | 1 | Active-low select |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that software leaves the polarity, phase, bit order and divisor untouched while an exchange is running, because the engine reads these fields live. They also assume that `miso` settles away from the rising edge. The bench follows both rules. It writes configuration only while the select is released, and it changes `miso` on the falling clock edge. It still writes the data register in the middle of an exchange, to show that such a write is ignored.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
   localparam logic [7:0] IDX_CTRL = 8'hF0;
   localparam logic [7:0] IDX_DIV  = 8'hF2;
   localparam logic [7:0] IDX_STAT = 8'hF3;
   localparam logic [7:0] IDX_DATA = 8'hF4;

   typedef struct packed {
      logic ie;
      logic men;
      logic cpol;
      logic cpha;
      logic lsbf;
   } spi_cfg_t;
endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DIV_W   = 3,
   parameter bit LSB_OPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_idx,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              spi_en_in,
   input  logic              busy,
   input  logic              done_pulse,
   input  logic [DATA_W-1:0] rx_byte,
   output spi_cfg_t          cfg,
   output logic [DIV_W-1:0]  div_code,
   output logic              start,
   output logic              irq
);
   logic done_q;
   logic lsbf_in;
   logic wr_ctrl, wr_div, wr_stat, wr_data;

   generate
      if (LSB_OPT) begin : g_lsb
         assign lsbf_in = reg_wdata[0];
      end else begin : g_msb_only
         assign lsbf_in = 1'b0;
      end
   endgenerate

   assign wr_ctrl = reg_wr && (reg_idx == IDX_CTRL);
   assign wr_div  = reg_wr && (reg_idx == IDX_DIV);
   assign wr_stat = reg_wr && (reg_idx == IDX_STAT);
   assign wr_data = reg_wr && (reg_idx == IDX_DATA);
   assign start   = wr_data && cfg.men && !busy;
   assign irq     = done_q && cfg.ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '{ie: 1'b0, men: 1'b1, cpol: 1'b0, cpha: 1'b0, lsbf: 1'b0};
         div_code <= DIV_W'(1);
         done_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            cfg.ie   <= reg_wdata[5];
            cfg.men  <= reg_wdata[4];
            cfg.cpol <= reg_wdata[3];
            cfg.cpha <= reg_wdata[2];
            cfg.lsbf <= lsbf_in;
         end
         if (wr_div)
            div_code <= reg_wdata[DIV_W-1:0];
         if (done_pulse)
            done_q <= 1'b1;
         else if (wr_stat && reg_wdata[7])
            done_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_idx)
         IDX_CTRL: reg_rdata[5:0] = {cfg.ie, cfg.men, cfg.cpol, cfg.cpha, 1'b0, cfg.lsbf};
         IDX_DIV:  reg_rdata[DIV_W-1:0] = div_code;
         IDX_STAT: begin
            reg_rdata[7] = done_q;
            reg_rdata[5] = spi_en_in;
            reg_rdata[0] = busy;
         end
         IDX_DATA: reg_rdata = rx_byte;
         default:  reg_rdata = '0;
      endcase
   end

   AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[7] && !done_pulse) |=> !done_q); // R9
endmodule

// File: rtl/spi_host_baud.sv
module spi_host_baud #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_code,
   output logic             bound
);
   localparam int MAX_HALF = 2 * ((1 << DIV_W) - 1);
   localparam int TW       = $clog2(MAX_HALF + 1);

   logic [TW-1:0] tick_q;
   logic [TW-1:0] half_len;

   assign half_len = (div_code == '0) ? TW'(1) : TW'({div_code, 1'b0});
   assign bound    = run && (tick_q == half_len - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_q <= '0;
      else if (!run || bound)
         tick_q <= '0;
      else
         tick_q <= tick_q + TW'(1);
   end

   AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $stable(div_code)) |-> (tick_q < half_len)); // R3
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
   import spi_host_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit LSB_OPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  spi_cfg_t          cfg,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              bound,
   input  logic              miso,
   output logic              busy,
   output logic              done_pulse,
   output logic [DATA_W-1:0] rx_byte,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n
);
   localparam int HALVES = 2 * DATA_W;
   localparam int HW     = $clog2(HALVES);

   logic              busy_q, sck_q;
   logic [HW-1:0]     half_q;
   logic [DATA_W-1:0] tx_q, rx_q, rx_hold;
   logic [DATA_W-1:0] tx_next, rx_next;
   logic              tx_bit, last;

   generate
      if (LSB_OPT) begin : g_order
         assign tx_bit  = cfg.lsbf ? tx_q[0] : tx_q[DATA_W-1];
         assign tx_next = cfg.lsbf ? (tx_q >> 1) : (tx_q << 1);
         assign rx_next = cfg.lsbf ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
      end else begin : g_msb
         assign tx_bit  = tx_q[DATA_W-1];
         assign tx_next = tx_q << 1;
         assign rx_next = {rx_q[DATA_W-2:0], miso};
      end
   endgenerate

   assign last       = (half_q == HW'(HALVES - 1));
   assign done_pulse = busy_q && bound && last;
   assign busy       = busy_q;
   assign rx_byte    = rx_hold;
   assign cs_n       = !busy_q;
   assign sck        = busy_q ? sck_q : cfg.cpol;
   assign mosi       = busy_q ? tx_bit : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         sck_q   <= 1'b0;
         half_q  <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         rx_hold <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            half_q <= '0;
            tx_q   <= tx_byte;
            sck_q  <= cfg.cpol ^ cfg.cpha;
         end
      end else if (bound) begin
         if (last) begin
            busy_q  <= 1'b0;
            sck_q   <= cfg.cpol;
            rx_hold <= rx_q;
         end else begin
            sck_q  <= !sck_q;
            half_q <= half_q + HW'(1);
            if (!half_q[0])
               rx_q <= rx_next;
            else
               tx_q <= tx_next;
         end
      end
   end

   AST_HALF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> (!busy_q || half_q == '0)); // R5
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DIV_W   = 3,
   parameter bit LSB_OPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_idx,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              spi_en_in,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n,
   output logic              irq
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
      if (DIV_W < 1 || DIV_W >= DATA_W) begin : g_bad_div
         $error("DIV_W must lie in 1..DATA_W-1");
      end
   endgenerate

   spi_cfg_t          cfg;
   logic [DIV_W-1:0]  div_code;
   logic              start, busy, done_pulse, bound;
   logic [DATA_W-1:0] rx_byte;

   spi_host_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LSB_OPT(LSB_OPT)) u_regs (
      .clk, .rst_n, .reg_idx, .reg_wr, .reg_wdata, .reg_rdata, .spi_en_in,
      .busy, .done_pulse, .rx_byte, .cfg, .div_code, .start, .irq
   );

   spi_host_baud #(.DIV_W(DIV_W)) u_baud (
      .clk, .rst_n, .run(busy), .div_code, .bound
   );

   spi_host_shifter #(.DATA_W(DATA_W), .LSB_OPT(LSB_OPT)) u_shift (
      .clk, .rst_n, .cfg, .start, .tx_byte(reg_wdata), .bound, .miso,
      .busy, .done_pulse, .rx_byte, .sck, .mosi, .cs_n
   );

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(cfg.men)); // R8
   AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $stable(cfg.cpol)) |-> $stable(sck)); // R4
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> reg_rdata_done_seen); // R9

   logic reg_rdata_done_seen;
   assign reg_rdata_done_seen = u_regs.done_q;
endmodule

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_idx = 8'h00;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       spi_en_in = 1'b1;
   logic       sck, mosi, cs_n, irq;
   logic       miso = 1'b0;

   int  vec = 0;
   int  mis = 0;
   bit  fin = 1'b0;

   // behavioural reference state
   bit       m_busy = 0, m_sck = 0, m_done = 0;
   bit       m_ie = 0, m_men = 1, m_cpol = 0, m_cpha = 0, m_lsbf = 0;
   int       m_div = 1, m_t = 0, m_ocnt = 0, m_scnt = 0;
   bit [7:0] m_txb = 0, m_rx = 0, m_rxout = 0, pat = 8'h00;

   always #4 clk = !clk;

   spi_host_ctrl u0 (
      .clk, .rst_n, .reg_idx, .reg_wr, .reg_wdata, .reg_rdata, .spi_en_in,
      .sck, .mosi, .miso, .cs_n, .irq
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      vec++;
      if (!ok) begin
         mis++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp_v, $time);
      end
   endtask

   // reference model: advances on each rising edge
   always @(posedge clk) begin
      bit was_busy, set_done;
      int h, b;
      if (!rst_n) begin
         m_busy = 0; m_sck = 0; m_done = 0; m_ie = 0; m_men = 1; m_cpol = 0;
         m_cpha = 0; m_lsbf = 0; m_div = 1; m_rxout = 0;
      end else begin
         was_busy = m_busy;
         set_done = 0;
         h = (m_div == 0) ? 1 : 2 * m_div;
         if (m_busy) begin
            m_t++;
            if (m_t % h == 0) begin
               b = m_t / h;
               if (b == 16) begin
                  m_busy = 0; m_sck = m_cpol; m_rxout = m_rx; set_done = 1;
               end else begin
                  m_sck = !m_sck;
                  if (b % 2 == 1) begin
                     if (m_lsbf) m_rx[m_scnt] = miso; else m_rx[7 - m_scnt] = miso;
                     m_scnt++;
                  end else m_ocnt++;
               end
            end
         end
         if (reg_wr) begin
            case (reg_idx)
               8'hF0: begin
                  m_ie = reg_wdata[5]; m_men = reg_wdata[4]; m_cpol = reg_wdata[3];
                  m_cpha = reg_wdata[2]; m_lsbf = reg_wdata[0];
               end
               8'hF2: m_div = reg_wdata[2:0];
               8'hF3: if (reg_wdata[7]) m_done = 0;
               8'hF4: if (!was_busy && m_men) begin
                  m_busy = 1; m_t = 0; m_ocnt = 0; m_scnt = 0; m_rx = 0;
                  m_sck = m_cpol ^ m_cpha; m_txb = reg_wdata;
               end
               default: ;
            endcase
         end
         if (set_done) m_done = 1;
      end
   end

   // per-cycle comparison and slave data, away from the rising edge
   always @(negedge clk) begin
      bit e_sck, e_mosi;
      if (rst_n && !fin) begin
         e_sck  = m_busy ? m_sck : m_cpol;
         e_mosi = m_busy ? (m_lsbf ? m_txb[m_ocnt] : m_txb[7 - m_ocnt]) : 1'b0;
         chk(sck == e_sck, "R4 R5 sck", sck, e_sck);
         chk(cs_n == !m_busy, "R7 cs_n", cs_n, !m_busy);
         chk(mosi == e_mosi, "R6 mosi", mosi, e_mosi);
         chk(irq == (m_done && m_ie), "R10 irq", irq, m_done && m_ie);
         if (m_scnt < 8) miso = m_lsbf ? pat[m_scnt] : pat[7 - m_scnt];
      end
   end

   task automatic wr(input logic [7:0] i, input logic [7:0] d);
      @(negedge clk);
      reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] i, output logic [7:0] d);
      reg_idx = i;
      #1;
      d = reg_rdata;
   endtask

   task automatic xfer(input bit pol, input bit pha, input bit lsb, input int dv,
                       input logic [7:0] txd, input logic [7:0] rxp, input bit ie,
                       input bit poke);
      logic [7:0] r;
      int cnt, h;
      h = (dv == 0) ? 1 : 2 * dv;
      wr(8'hF2, 8'(dv));
      rd(8'hF2, r);
      chk(r == 8'(dv), "R3 divisor readback", r, dv);
      wr(8'hF0, {2'b00, ie, 1'b1, pol, pha, 1'b0, lsb});
      pat = rxp;
      wr(8'hF4, txd);
      cnt = 0;
      while (cs_n == 1'b0) begin
         if (cnt == 10) begin
            rd(8'hF3, r);
            chk(r[0] == 1'b1, "R9 busy bit", r[0], 1);
         end
         if (poke && cnt == 20) begin
            reg_idx = 8'hF4; reg_wdata = ~txd; reg_wr = 1'b1; // R7 ignored while busy
            @(negedge clk);
            reg_wr = 1'b0;
            cnt++;
         end else begin
            cnt++;
            @(negedge clk);
         end
      end
      chk(cnt == 16 * h, "R3 select length", cnt, 16 * h);
      rd(8'hF3, r);
      chk(r[7] == 1'b1, "R9 done set", r[7], 1);
      chk(irq == ie, "R10 irq after done", irq, ie);
      rd(8'hF4, r);
      chk(r == rxp, "R11 received byte", r, rxp);
      wr(8'hF3, 8'h80);
      rd(8'hF3, r);
      chk(r[7] == 1'b0, "R9 w1c", r[7], 0);
      chk(irq == 1'b0, "R10 irq cleared", irq, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         mis++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         fin = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(8'hF0, r); chk(r == 8'h10, "R1 ctrl reset", r, 8'h10);
      rd(8'hF2, r); chk(r == 8'h01, "R1 div reset", r, 8'h01);
      rd(8'hF4, r); chk(r == 8'h00, "R1 data reset", r, 8'h00);
      rd(8'hF3, r); chk(r == 8'h20, "R1 R9 status reset", r, 8'h20);
      chk(cs_n == 1'b1 && sck == 1'b0 && irq == 1'b0, "R1 pins reset",
          {cs_n, sck, irq}, 3'b100);
      // R2 field packing and reserved bits
      wr(8'hF0, 8'hFF);
      rd(8'hF0, r); chk(r == 8'h3D, "R2 ctrl fields", r, 8'h3D);
      wr(8'hF0, 8'h10);
      rd(8'hF0, r); chk(r == 8'h10, "R2 ctrl rewrite", r, 8'h10);
      // R9 enable mirror
      spi_en_in = 1'b0;
      rd(8'hF3, r); chk(r == 8'h00, "R9 enable mirror low", r, 8'h00);
      spi_en_in = 1'b1;
      rd(8'hF3, r); chk(r == 8'h20, "R9 enable mirror high", r, 8'h20);
      // exchanges across modes, orders and divisors
      xfer(0, 0, 0, 0, 8'hA5, 8'h3C, 1, 0);
      xfer(0, 1, 0, 1, 8'h96, 8'hE1, 0, 0);
      xfer(1, 0, 1, 3, 8'h0F, 8'h81, 1, 0);
      xfer(1, 1, 1, 7, 8'hC3, 8'h5A, 1, 0);
      xfer(0, 1, 1, 2, 8'h01, 8'h80, 0, 1);
      xfer(1, 0, 0, 1, 8'h80, 8'h01, 1, 1);
      // R8 master enable off blocks a start
      wr(8'hF0, 8'h08);
      wr(8'hF4, 8'hFF);
      repeat (20) begin
         @(negedge clk);
         chk(cs_n == 1'b1, "R8 no start", cs_n, 1);
      end
      rd(8'hF4, r); chk(r == 8'h01, "R8 R11 data kept", r, 8'h01);
      fin = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end
endmodule